// File: doc/BRIEF.md
# GPIO Expander Register and Interrupt Core

This block is the register file and pin-control logic behind an eight-line general purpose I/O expander. A byte-wide register port, typically fed by an I2C target front end, reads and writes a small set of configuration registers. These registers set each line's direction, output level, output tri-state, pull resistor enable and pull polarity, expected input level and interrupt mask. The block drives per-pin output-enable, output-level, pull-enable and pull-select signals for external pads.

The block samples the pin inputs through a two-stage synchronizer. It raises a sticky status bit for any input line whose level differs from its programmed expected level. Reading the status register clears it. An active-low interrupt output is driven low while any unmasked status bit is set. A power-cycle flag in the identification register also drives it while interrupts are enabled. Reading the identification register clears that flag. Writing the software reset bit restores every register to its power-on value.

Top module: `gpx_core`

## Requirements
- R1: When `rst` is high at a clock edge, all registers take their power-on values: direction 0x00, output level 0x00, tri-state 0xFF, expected level 0xFF, pull enable 0xFF, pull polarity 0xFF, mask 0xFF, status 0x00, power-cycle flag 1. The outputs then read `pin_oe`=0x00, `pin_out`=0x00, `pull_en`=0xFF, `pull_up`=0xFF, `irq_n`=1 and `reg_rdata`=0x00.
- R2: A read of address 0x01 returns {3'b101, FW_REV[2:0], power-cycle flag, 1'b0}. The read clears the power-cycle flag, so an immediate second read returns bit 1 as 0.
- R3: `pin_oe` bit i is 1 only when direction bit i (address 0x03, 1 = output) is 1 and tri-state bit i (address 0x07) is 0. `pin_out` equals the output level register (address 0x05).
- R4: `pull_en` bit i is pull-enable bit i (address 0x0B) gated by the line being an input. `pull_up` equals the pull polarity register (address 0x0D, 1 = pull-up, 0 = pull-down).
- R5: A read of address 0x0F returns the pin levels after the two-stage synchronizer (1 = high). A change on `pin_in` becomes visible there two clock edges later.
- R6: Status bit i (address 0x13) sets when line i is an input and its synchronized level differs from expected-level bit i (address 0x09). It stays set until the status register is read. A read clears only the bits that do not set again in that same cycle.
- R7: `irq_n` is 0 when any status bit with mask bit 0 (address 0x11, 1 = masked) is set. It is also 0 when the power-cycle flag is set and at least one mask bit is 0. Otherwise it is 1.
- R8: Writing a value with bit 0 set to address 0x01 returns all registers to their R1 values, including the power-cycle flag. Bit 0 always reads back 0.
- R9: Writes to 0x0F, 0x13 and unmapped addresses change nothing. Reads of unmapped addresses return 0x00.
- R10: `reg_rdata` updates at the clock edge that samples `reg_rd`. `pin_oe`, `pin_out`, `pull_en`, `pull_up` and `irq_n` are registered, and follow a register change one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output level |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull polarity, 1 = up |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `reset` is held high across the first clock edge, and that `reg_addr` and `reg_wdata` are stable whenever a strobe is high at an edge. They assume that `pin_in` is free to change at any time, since the synchronizer absorbs it. The stimulus drives every input only on the falling clock edge and asserts reset from time zero. It changes pins in single-cycle pulses as well as in held levels, so both the sticky capture of a status bit and its re-setting during a clearing read are reached.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int GPX_W = 8;

  localparam logic [7:0] A_ID    = 8'h01;
  localparam logic [7:0] A_DIR   = 8'h03;
  localparam logic [7:0] A_OUT   = 8'h05;
  localparam logic [7:0] A_HIZ   = 8'h07;
  localparam logic [7:0] A_DFLT  = 8'h09;
  localparam logic [7:0] A_PEN   = 8'h0B;
  localparam logic [7:0] A_PMODE = 8'h0D;
  localparam logic [7:0] A_PINS  = 8'h0F;
  localparam logic [7:0] A_MASK  = 8'h11;
  localparam logic [7:0] A_STAT  = 8'h13;

  localparam logic [2:0] VENDOR_CODE = 3'b101;

  typedef struct packed {
    logic [GPX_W-1:0] dir;
    logic [GPX_W-1:0] lvl;
    logic [GPX_W-1:0] hiz;
    logic [GPX_W-1:0] dflt;
    logic [GPX_W-1:0] pen;
    logic [GPX_W-1:0] pmode;
    logic [GPX_W-1:0] mask;
  } gpx_cfg_t;

  localparam gpx_cfg_t CFG_POR = '{
    dir:   '0,
    lvl:   '0,
    hiz:   '1,
    dflt:  '1,
    pen:   '1,
    pmode: '1,
    mask:  '1
  };
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= INIT;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
  import gpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output gpx_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg <= CFG_POR;
    end else if (wr) begin
      case (addr)
        A_DIR:   cfg.dir   <= wdata;
        A_OUT:   cfg.lvl   <= wdata;
        A_HIZ:   cfg.hiz   <= wdata;
        A_DFLT:  cfg.dflt  <= wdata;
        A_PEN:   cfg.pen   <= wdata;
        A_PMODE: cfg.pmode <= wdata;
        A_MASK:  cfg.mask  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         clr_stat,
  input  logic         clr_flag,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] dflt,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         por_flag,
  output logic         irq_n
);
  logic [W-1:0] mismatch;
  logic         pending;

  assign mismatch = (pins_s ^ dflt) & ~dir;
  assign pending  = (|(status & ~mask)) || (por_flag && !(&mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      por_flag <= 1'b1;
      irq_n    <= 1'b1;
    end else begin
      irq_n <= !pending;
      if (soft_rst) begin
        status   <= '0;
        por_flag <= 1'b1;
      end else begin
        status <= (clr_stat ? '0 : status) | mismatch;
        if (clr_flag) por_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter logic [2:0] FW_REV      = 3'd2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [GPX_W-1:0] pin_in,
  output logic [GPX_W-1:0] pin_oe,
  output logic [GPX_W-1:0] pin_out,
  output logic [GPX_W-1:0] pull_en,
  output logic [GPX_W-1:0] pull_up,
  output logic             irq_n
);
  gpx_cfg_t         cfg;
  logic [GPX_W-1:0] pins_s;
  logic [GPX_W-1:0] status;
  logic             por_flag;
  logic             soft_rst;
  logic [7:0]       rd_mux;

  assign soft_rst = reg_wr && (reg_addr == A_ID) && reg_wdata[0];

  gpx_sync #(.W(GPX_W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
  );

  gpx_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg)
  );

  gpx_irq #(.W(GPX_W)) u_irq (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .clr_stat(reg_rd && (reg_addr == A_STAT)),
    .clr_flag(reg_rd && (reg_addr == A_ID)),
    .pins_s(pins_s), .dflt(cfg.dflt), .dir(cfg.dir), .mask(cfg.mask),
    .status(status), .por_flag(por_flag), .irq_n(irq_n)
  );

  always_comb begin
    case (reg_addr)
      A_ID:    rd_mux = {VENDOR_CODE, FW_REV, por_flag, 1'b0};
      A_DIR:   rd_mux = cfg.dir;
      A_OUT:   rd_mux = cfg.lvl;
      A_HIZ:   rd_mux = cfg.hiz;
      A_DFLT:  rd_mux = cfg.dflt;
      A_PEN:   rd_mux = cfg.pen;
      A_PMODE: rd_mux = cfg.pmode;
      A_PINS:  rd_mux = pins_s;
      A_MASK:  rd_mux = cfg.mask;
      A_STAT:  rd_mux = status;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
      pin_oe    <= '0;
      pin_out   <= '0;
      pull_en   <= '1;
      pull_up   <= '1;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      pin_oe  <= cfg.dir & ~cfg.hiz;
      pin_out <= cfg.lvl;
      pull_en <= cfg.pen & ~cfg.dir;
      pull_up <= cfg.pmode;
    end
  end
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] pin_oe,
  input logic [7:0] pull_en,
  input logic       irq_n
);
  logic mapped;
  assign mapped = reg_addr[0] && (reg_addr <= 8'h13);

  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (reg_rdata == 8'h00 && irq_n && pin_oe == 8'h00 && pull_en == 8'hFF));

  a_r2_id_code: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 8'h01) |=> (reg_rdata[7:5] == 3'b101 && !reg_rdata[0]));

  a_r4_pull_input_only: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & pull_en) == 8'h00);

  a_r8_sw_reset: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h01 && reg_wdata[0]) |=> ##1 (pin_oe == 8'h00 && irq_n));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> (reg_rdata == 8'h00));
endmodule

bind gpx_core gpx_core_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pin_oe(pin_oe), .pull_en(pull_en), .irq_n(irq_n)
);

// File: tb/test_gpx_core.sv
module test_gpx_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] pin_oe, pin_out, pull_en, pull_up;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done = 0;
  bit started = 0;

  always #10 clk = ~clk;

  gpx_core i_gpx_core (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .irq_n(irq_n)
  );

  // behavioural reference: register array indexed by address
  int   m_reg [int];
  int   m_hist [$];
  int   m_stat, m_flag;
  int   e_oe, e_out, e_pe, e_pu, e_irq, e_rd;

  function automatic void m_por();
    m_reg[3] = 0;     m_reg[5] = 0;     m_reg[7] = 255;
    m_reg[9] = 255;   m_reg[11] = 255;  m_reg[13] = 255;
    m_reg[17] = 255;
    m_stat = 0; m_flag = 1;
  endfunction

  function automatic int m_read(int a);
    if (a == 1)  return 160 + 2 * 4 + m_flag * 2;
    if (a == 15) return m_hist[1];
    if (a == 19) return m_stat;
    if (m_reg.exists(a)) return m_reg[a];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_por();
      m_hist = '{255, 255};
      e_oe = 0; e_out = 0; e_pe = 255; e_pu = 255; e_irq = 1; e_rd = 0;
    end else begin
      int a, mism, unmasked;
      a = int'(reg_addr);
      e_oe  = m_reg[3] & ~m_reg[7] & 255;
      e_out = m_reg[5];
      e_pe  = m_reg[11] & ~m_reg[3] & 255;
      e_pu  = m_reg[13];
      unmasked = ~m_reg[17] & 255;
      e_irq = ((m_stat & unmasked) != 0 || (m_flag == 1 && unmasked != 0)) ? 0 : 1;
      if (reg_rd) e_rd = m_read(a);
      mism = (m_hist[1] ^ m_reg[9]) & ~m_reg[3] & 255;
      if (reg_wr && a == 1 && reg_wdata[0]) begin
        m_por();
      end else begin
        m_stat = ((reg_rd && a == 19) ? 0 : m_stat) | mism;
        if (reg_rd && a == 1) m_flag = 0;
        if (reg_wr && m_reg.exists(a)) m_reg[a] = int'(reg_wdata);
      end
      m_hist.push_front(int'(pin_in));
      void'(m_hist.pop_back());
    end
    started = 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3 pin_oe",   int'(pin_oe),  e_oe);
      chk("R3 pin_out",  int'(pin_out), e_out);
      chk("R4 pull_en",  int'(pull_en), e_pe);
      chk("R4 pull_up",  int'(pull_up), e_pu);
      chk("R7 irq_n",    int'(irq_n),   e_irq);
      chk("R10 rdata",   int'(reg_rdata), e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
    reg_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 oe", int'(pin_oe), 0);
    chk("R1 pull_en", int'(pull_en), 255);
    chk("R1 irq_n", int'(irq_n), 1);
    rd(8'h11, v); chk("R1 mask", v, 255);
    rd(8'h07, v); chk("R1 hiz", v, 255);
    // R2 ID read clears power-cycle flag
    rd(8'h01, v); chk("R2 id first", v, 8'hAA);
    rd(8'h01, v); chk("R2 id second", v, 8'hA8);
    // R3 direction, level, tri-state
    wr(8'h05, 8'h5A); wr(8'h03, 8'h0F); wr(8'h07, 8'h03);
    idle(1);
    chk("R3 oe", int'(pin_oe), 8'h0C);
    chk("R3 out", int'(pin_out), 8'h5A);
    // R4 pulls
    wr(8'h0D, 8'h33); idle(1);
    chk("R4 pull_en", int'(pull_en), 8'hF0);
    chk("R4 pull_up", int'(pull_up), 8'h33);
    // R5 input sampling latency
    wr(8'h03, 8'h00); wr(8'h09, 8'hC3);
    pin_in = 8'hC3; idle(3);
    rd(8'h0F, v); chk("R5 pins", v, 8'hC3);
    rd(8'h13, v); idle(2);
    rd(8'h13, v); chk("R6 clean", v, 0);
    // R6 single-cycle pulse is latched; R7 irq on unmasked bit
    wr(8'h11, 8'hFE);
    pin_in = 8'hC2; @(negedge clk); pin_in = 8'hC3;
    idle(4);
    chk("R7 irq low", int'(irq_n), 0);
    rd(8'h13, v); chk("R6 latched", v, 8'h01);
    idle(1);
    rd(8'h13, v); chk("R6 cleared", v, 0);
    idle(1);
    chk("R7 irq released", int'(irq_n), 1);
    // R6 held mismatch re-sets during clearing read
    pin_in = 8'h43; idle(4);
    rd(8'h13, v); chk("R6 held a", v, 8'h80);
    rd(8'h13, v); chk("R6 held b", v, 8'h80);
    chk("R7 masked pin", int'(irq_n), 1);
    pin_in = 8'hC3; idle(3);
    rd(8'h13, v); rd(8'h13, v); chk("R6 gone", v, 0);
    // R9 read-only and unmapped writes ignored
    wr(8'h0F, 8'h00); wr(8'h13, 8'hFF); wr(8'h20, 8'h12); wr(8'h04, 8'h77);
    rd(8'h20, v); chk("R9 unmapped", v, 0);
    rd(8'h04, v); chk("R9 even", v, 0);
    rd(8'h13, v); chk("R9 stat ro", v, 0);
    rd(8'h0F, v); chk("R9 pins ro", v, 8'hC3);
    rd(8'h05, v); chk("R9 out kept", v, 8'h5A);
    // R8 software reset
    wr(8'h03, 8'hFF); wr(8'h07, 8'h00); idle(1);
    chk("R8 pre oe", int'(pin_oe), 255);
    wr(8'h01, 8'h01); idle(1);
    chk("R8 oe", int'(pin_oe), 0);
    rd(8'h01, v); chk("R8 id flag", v, 8'hAA);
    rd(8'h03, v); chk("R8 dir", v, 0);
    rd(8'h11, v); chk("R8 mask", v, 255);
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule